// File: doc/BRIEF.md
# LCD Power-State and Status Controller

This block holds the display-control flags of a graphic LCD controller: panel enable, force-all-pixels-on, polarity inversion, icon-only view, static icon, column direction, bias choice, common scan order and the three supply-control bits. It turns the flags into one operating mode and drives the enables for the oscillator, the charge-pump and regulator chain, the multiplexed row and column drivers and the static icon driver. It also drives an active-low blanking line and assembles the byte returned on a status read.

There is no command that selects a low-power mode directly. Power save is inferred whenever the panel is disabled while force-all-on is set. The static-icon flag then chooses standby, where the oscillator and icon driver keep running, or sleep, where everything stops. Commands reach the block as pre-decoded one-cycle strobes that share a small data field. A soft reset strobe clears most flags but leaves force-all-on alone, so a soft reset issued in standby drops the block into sleep.

Top module: `lcd_pwr_status_ctrl`

## Requirements
- R1: With the panel enabled, modeCode is 0 (normal) when force-all-on is clear and 1 (all-lit) when it is set; with the panel disabled and force-all-on clear, modeCode is 2 (all-off).
- R2: With the panel disabled and force-all-on set, the block is in power save: modeCode is 3 (standby) when the static icon flag is 1 and 4 (sleep) when it is 0.
- R3: In sleep, oscEn, dutyDriveEn and staticIconEn are 0 and supplyCtl is 000.
- R4: In standby, oscEn and staticIconEn are 1, dutyDriveEn is 0 and supplyCtl is 000.
- R5: A softReset strobe clears panel enable, polarity, icon-only, static icon, bias (to 0, meaning 1/9), common order (to 0, normal) and the supply bits, sets column direction to normal, and keeps force-all-on; from standby it therefore leads to sleep.
- R6: statusByte is {busy, columnNormal, panelDisabled, resetActive, powerSave, iconOnly, reverse, allLit} from bit 7 down to bit 0.
- R7: After rstN is released the state is: panel disabled, force-all-on clear, polarity normal, column direction normal, supply bits 000, bias 0, static icon off, common order 0, not in power save (statusByte 0x60 once busy has cleared).
- R8: blankN is 0 while in power save and 1 otherwise.
- R9: Busy (bit 7) and reset-active (bit 4) are 1 while rstN is low and for BUSY_CYCLES rising clock edges after its release; every strobe seen during that time is ignored.
- R10: A strobe that sets panel enable (wrDisplay with cmdData[0]=1) or clears force-all-on (wrAllLit with cmdData[0]=0) ends power save, and supplyCtl shows the stored supply bits from the edge that captures it.
- R11: Outside power save, oscEn is 1, supplyCtl equals the stored supply bits, dutyDriveEn is 1 only when the panel is enabled, and staticIconEn follows the static icon flag.
- R12: When softReset arrives in the same cycle as other strobes, the reset wins and the other strobes have no effect.
- R13: Each flag strobe loads cmdData[0] into its flag (wrAdc: 1 = normal column direction; wrBias: 1 = 1/7); wrPowerCtl loads all of cmdData; biasSel and comOrderRev show the stored bias and common order flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Hardware reset, active low, asynchronous |
| wrDisplay | input | 1 | Load panel enable from cmdData[0] |
| wrAllLit | input | 1 | Load force-all-on from cmdData[0] |
| wrReverse | input | 1 | Load polarity inversion from cmdData[0] |
| wrIconOnly | input | 1 | Load icon-only view from cmdData[0] |
| wrAdc | input | 1 | Load column direction from cmdData[0] (1 = normal) |
| wrStaticIcon | input | 1 | Load static icon flag from cmdData[0] |
| wrBias | input | 1 | Load bias choice from cmdData[0] (1 = 1/7) |
| wrComOrder | input | 1 | Load common scan order from cmdData[0] (1 = reversed) |
| wrPowerCtl | input | 1 | Load supply-control bits from cmdData |
| softReset | input | 1 | Soft reset command strobe |
| cmdData | input | PWR_W | Data bits of the strobed command |
| oscEn | output | 1 | Oscillator enable |
| supplyCtl | output | PWR_W | Effective supply-control bits (zero in power save) |
| dutyDriveEn | output | 1 | Multiplexed row/column driver enable |
| staticIconEn | output | 1 | Static icon driver enable |
| blankN | output | 1 | Blanking output, low in power save |
| biasSel | output | 1 | Bias choice, 0 = 1/9, 1 = 1/7 |
| comOrderRev | output | 1 | Common scan order, 1 = reversed |
| modeCode | output | 3 | Operating mode code |
| statusByte | output | 8 | Status read byte |

## Verification
The hardest state to reach is sleep entered through a soft reset taken in standby, since it needs force-all-on set, the panel disabled and the static icon on, all after the busy window has closed. The bench builds that path one strobe at a time and checks the standby outputs before it issues the reset. It also places strobes inside the busy window right after reset release and pairs softReset with a panel-enable write in one cycle, then reads the status byte to confirm that both were ignored.

// File: rtl/lcd_pwr_pkg.sv
package lcd_pwr_pkg;

  typedef enum logic [2:0] {
    MODE_NORMAL  = 3'd0,
    MODE_ALLLIT  = 3'd1,
    MODE_ALLOFF  = 3'd2,
    MODE_STANDBY = 3'd3,
    MODE_SLEEP   = 3'd4
  } lcdMode_e;

  typedef struct packed {
    logic wrDisp;
    logic wrAll;
    logic wrRev;
    logic wrIcon;
    logic wrAdc;
    logic wrStatic;
    logic wrBias;
    logic wrCom;
    logic wrPwr;
    logic clear;
  } flagStrobe_t;

endpackage

// File: rtl/lcd_pwr_ctrl.sv
module lcd_pwr_ctrl
  import lcd_pwr_pkg::*;
#(
  parameter int BUSY_CYCLES = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrDisplay,
  input  logic        wrAllLit,
  input  logic        wrReverse,
  input  logic        wrIconOnly,
  input  logic        wrAdc,
  input  logic        wrStaticIcon,
  input  logic        wrBias,
  input  logic        wrComOrder,
  input  logic        wrPowerCtl,
  input  logic        softReset,
  output flagStrobe_t strb,
  output logic        busy
);

  localparam int CNT_W = $clog2(BUSY_CYCLES + 1);

  logic [CNT_W-1:0] busyCnt;

  // Busy window: loaded while reset is held, counts down after release.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyCnt <= CNT_W'(BUSY_CYCLES);
    end else if (busyCnt != '0) begin
      busyCnt <= busyCnt - CNT_W'(1);
    end
  end

  assign busy = (busyCnt != '0);

  // Strobes are dropped while busy; a soft reset masks all others.
  always_comb begin
    strb = '0;
    if (!busy) begin
      if (softReset) begin
        strb.clear = 1'b1;
      end else begin
        strb.wrDisp   = wrDisplay;
        strb.wrAll    = wrAllLit;
        strb.wrRev    = wrReverse;
        strb.wrIcon   = wrIconOnly;
        strb.wrAdc    = wrAdc;
        strb.wrStatic = wrStaticIcon;
        strb.wrBias   = wrBias;
        strb.wrCom    = wrComOrder;
        strb.wrPwr    = wrPowerCtl;
      end
    end
  end

  // R9: once the busy window has closed it never reopens without reset
  assert_busy_once_R9: assert property (@(posedge clk) disable iff (!rstN)
    !busy |=> !busy);

  // R12: while a soft reset is decoded no flag write is passed on
  assert_clear_alone_R12: assert property (@(posedge clk) disable iff (!rstN)
    strb.clear |-> !(strb.wrDisp || strb.wrAll || strb.wrPwr || strb.wrStatic));

endmodule

// File: rtl/lcd_pwr_regs.sv
module lcd_pwr_regs
  import lcd_pwr_pkg::*;
#(
  parameter int PWR_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  flagStrobe_t      strb,
  input  logic [PWR_W-1:0] cmdData,
  input  logic             busy,
  output logic             oscEn,
  output logic [PWR_W-1:0] supplyCtl,
  output logic             dutyDriveEn,
  output logic             staticIconEn,
  output logic             blankN,
  output logic             biasSel,
  output logic             comOrderRev,
  output lcdMode_e         mode,
  output logic [7:0]       statusByte
);

  logic             dispOn;
  logic             allLit;
  logic             reverse;
  logic             iconOnly;
  logic             adcNormal;
  logic             staticOn;
  logic             bias17;
  logic             comRev;
  logic [PWR_W-1:0] pwrCtl;
  logic             psave;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dispOn    <= 1'b0;
      allLit    <= 1'b0;
      reverse   <= 1'b0;
      iconOnly  <= 1'b0;
      adcNormal <= 1'b1;
      staticOn  <= 1'b0;
      bias17    <= 1'b0;
      comRev    <= 1'b0;
      pwrCtl    <= '0;
    end else if (strb.clear) begin
      // force-all-on is deliberately kept
      dispOn    <= 1'b0;
      reverse   <= 1'b0;
      iconOnly  <= 1'b0;
      adcNormal <= 1'b1;
      staticOn  <= 1'b0;
      bias17    <= 1'b0;
      comRev    <= 1'b0;
      pwrCtl    <= '0;
    end else begin
      if (strb.wrDisp)   dispOn    <= cmdData[0];
      if (strb.wrAll)    allLit    <= cmdData[0];
      if (strb.wrRev)    reverse   <= cmdData[0];
      if (strb.wrIcon)   iconOnly  <= cmdData[0];
      if (strb.wrAdc)    adcNormal <= cmdData[0];
      if (strb.wrStatic) staticOn  <= cmdData[0];
      if (strb.wrBias)   bias17    <= cmdData[0];
      if (strb.wrCom)    comRev    <= cmdData[0];
      if (strb.wrPwr)    pwrCtl    <= cmdData;
    end
  end

  assign psave = !dispOn && allLit;

  always_comb begin
    if (psave)       mode = staticOn ? MODE_STANDBY : MODE_SLEEP;
    else if (dispOn) mode = allLit ? MODE_ALLLIT : MODE_NORMAL;
    else             mode = MODE_ALLOFF;
  end

  always_comb begin
    unique case (mode)
      MODE_SLEEP: begin
        oscEn        = 1'b0;
        supplyCtl    = '0;
        dutyDriveEn  = 1'b0;
        staticIconEn = 1'b0;
      end
      MODE_STANDBY: begin
        oscEn        = 1'b1;
        supplyCtl    = '0;
        dutyDriveEn  = 1'b0;
        staticIconEn = 1'b1;
      end
      MODE_ALLOFF: begin
        oscEn        = 1'b1;
        supplyCtl    = pwrCtl;
        dutyDriveEn  = 1'b0;
        staticIconEn = staticOn;
      end
      default: begin
        oscEn        = 1'b1;
        supplyCtl    = pwrCtl;
        dutyDriveEn  = 1'b1;
        staticIconEn = staticOn;
      end
    endcase
  end

  assign blankN      = !psave;
  assign biasSel     = bias17;
  assign comOrderRev = comRev;
  assign statusByte  = {busy, adcNormal, !dispOn, busy, psave, iconOnly, reverse, allLit};

  // R5: a soft reset taken in standby lands in sleep
  assert_standby_to_sleep_R5: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_STANDBY && strb.clear) |=> (mode == MODE_SLEEP));

  // R12: a soft reset always leaves the panel disabled
  assert_clear_wins_R12: assert property (@(posedge clk) disable iff (!rstN)
    strb.clear |=> !statusByte[6-1] == 1'b0);

  // R3: sleep stops every driver and the oscillator
  assert_sleep_quiet_R3: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_SLEEP) |-> (!oscEn && !dutyDriveEn && !staticIconEn && supplyCtl == '0));

  // R4: standby keeps oscillator and icon drive only
  assert_standby_gates_R4: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_STANDBY) |-> (oscEn && staticIconEn && !dutyDriveEn && supplyCtl == '0));

  // R8: blanking line is low in either power-save mode
  assert_blank_low_R8: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_STANDBY || mode == MODE_SLEEP) |-> !blankN);

  // R10: a wake write restores the stored supply bits at once
  assert_wake_supply_R10: assert property (@(posedge clk) disable iff (!rstN)
    (psave && strb.wrDisp && cmdData[0] && !strb.wrPwr && !strb.clear)
      |=> (supplyCtl == $past(pwrCtl) && blankN));

endmodule

// File: rtl/lcd_pwr_status_ctrl.sv
module lcd_pwr_status_ctrl
  import lcd_pwr_pkg::*;
#(
  parameter int BUSY_CYCLES = 4,
  parameter int PWR_W       = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrDisplay,
  input  logic             wrAllLit,
  input  logic             wrReverse,
  input  logic             wrIconOnly,
  input  logic             wrAdc,
  input  logic             wrStaticIcon,
  input  logic             wrBias,
  input  logic             wrComOrder,
  input  logic             wrPowerCtl,
  input  logic             softReset,
  input  logic [PWR_W-1:0] cmdData,
  output logic             oscEn,
  output logic [PWR_W-1:0] supplyCtl,
  output logic             dutyDriveEn,
  output logic             staticIconEn,
  output logic             blankN,
  output logic             biasSel,
  output logic             comOrderRev,
  output logic [2:0]       modeCode,
  output logic [7:0]       statusByte
);

  flagStrobe_t strb;
  logic        busy;
  lcdMode_e    mode;

  lcd_pwr_ctrl #(.BUSY_CYCLES(BUSY_CYCLES)) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .wrDisplay    (wrDisplay),
    .wrAllLit     (wrAllLit),
    .wrReverse    (wrReverse),
    .wrIconOnly   (wrIconOnly),
    .wrAdc        (wrAdc),
    .wrStaticIcon (wrStaticIcon),
    .wrBias       (wrBias),
    .wrComOrder   (wrComOrder),
    .wrPowerCtl   (wrPowerCtl),
    .softReset    (softReset),
    .strb         (strb),
    .busy         (busy)
  );

  lcd_pwr_regs #(.PWR_W(PWR_W)) u_regs (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .cmdData      (cmdData),
    .busy         (busy),
    .oscEn        (oscEn),
    .supplyCtl    (supplyCtl),
    .dutyDriveEn  (dutyDriveEn),
    .staticIconEn (staticIconEn),
    .blankN       (blankN),
    .biasSel      (biasSel),
    .comOrderRev  (comOrderRev),
    .mode         (mode),
    .statusByte   (statusByte)
  );

  assign modeCode = mode;

endmodule

// File: tb/sim_lcd_pwr_status_ctrl.sv
module sim_lcd_pwr_status_ctrl;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [9:0] cmdVec = '0;
  logic [2:0] cmdData = '0;
  logic       oscEn, dutyDriveEn, staticIconEn, blankN, biasSel, comOrderRev;
  logic [2:0] supplyCtl, modeCode;
  logic [7:0] statusByte;
  int         nChecks = 0;
  int         nErrors = 0;

  // strobe index map
  localparam int S_DISP = 0, S_ALL = 1, S_REV = 2, S_ICON = 3, S_ADC = 4;
  localparam int S_STAT = 5, S_BIAS = 6, S_COM = 7, S_PWR = 8, S_SRST = 9;

  always #2.5 clk = ~clk;

  lcd_pwr_status_ctrl u0 (
    .clk(clk), .rstN(rstN),
    .wrDisplay(cmdVec[S_DISP]), .wrAllLit(cmdVec[S_ALL]), .wrReverse(cmdVec[S_REV]),
    .wrIconOnly(cmdVec[S_ICON]), .wrAdc(cmdVec[S_ADC]), .wrStaticIcon(cmdVec[S_STAT]),
    .wrBias(cmdVec[S_BIAS]), .wrComOrder(cmdVec[S_COM]), .wrPowerCtl(cmdVec[S_PWR]),
    .softReset(cmdVec[S_SRST]), .cmdData(cmdData),
    .oscEn(oscEn), .supplyCtl(supplyCtl), .dutyDriveEn(dutyDriveEn),
    .staticIconEn(staticIconEn), .blankN(blankN), .biasSel(biasSel),
    .comOrderRev(comOrderRev), .modeCode(modeCode), .statusByte(statusByte)
  );

  task automatic check(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nErrors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // drive one strobe for one cycle; results are sampled on the following negedge
  task automatic issue(input int idx, input logic [2:0] d);
    @(negedge clk);
    cmdVec = '0;
    cmdVec[idx] = 1'b1;
    cmdData = d;
    @(negedge clk);
    cmdVec = '0;
    cmdData = '0;
  endtask

  // gates packed as {osc, supply[2:0], duty, icon, blankN}
  function automatic int gates();
    return {oscEn, supplyCtl, dutyDriveEn, staticIconEn, blankN};
  endfunction

  task automatic t_reset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    check("R9 status during reset", statusByte, 8'hF0);
    rstN = 1'b1;
    cmdVec[S_DISP] = 1'b1;            // attempt during busy window
    cmdData = 3'd1;
    @(negedge clk);
    cmdVec = '0;
    cmdData = '0;
    repeat (2) @(negedge clk);        // three edges since release
    check("R9 busy still set", statusByte, 8'hF0);
    @(negedge clk);                   // fourth edge
    check("R7 status after busy", statusByte, 8'h60);
    check("R7 mode all-off", modeCode, 2);
    check("R7 bias/com", {biasSel, comOrderRev}, 0);
    check("R11 gates all-off", gates(), 7'b1_000_0_0_1);
  endtask

  task automatic t_normal();
    issue(S_PWR, 3'd7);
    check("R11 supply bits", supplyCtl, 7);
    issue(S_DISP, 3'd1);
    check("R1 normal mode", modeCode, 0);
    check("R6 status normal", statusByte, 8'h40);
    check("R11 gates normal", gates(), 7'b1_111_1_0_1);
    issue(S_ALL, 3'd1);
    check("R1 all-lit mode", modeCode, 1);
    check("R6 status all-lit", statusByte, 8'h41);
  endtask

  task automatic t_sleep_wake();
    issue(S_DISP, 3'd0);
    check("R2 sleep mode", modeCode, 4);
    check("R3 sleep gates", gates(), 7'b0_000_0_0_0);
    check("R8 blank low", blankN, 0);
    check("R6 status sleep", statusByte, 8'h69);
    issue(S_DISP, 3'd1);
    check("R10 wake mode", modeCode, 1);
    check("R10 supply restored", supplyCtl, 7);
    check("R8 blank high", blankN, 1);
  endtask

  task automatic t_standby_reset();
    issue(S_STAT, 3'd1);
    issue(S_BIAS, 3'd1);
    issue(S_COM, 3'd1);
    check("R13 bias/com set", {biasSel, comOrderRev}, 3);
    issue(S_DISP, 3'd0);
    check("R2 standby mode", modeCode, 3);
    check("R4 standby gates", gates(), 7'b1_000_0_1_0);
    issue(S_SRST, 3'd0);
    check("R5 sleep after reset", modeCode, 4);
    check("R5 flags cleared", {biasSel, comOrderRev}, 0);
    issue(S_ALL, 3'd0);
    check("R10 wake by all-lit off", modeCode, 2);
    check("R5 supply bits cleared", supplyCtl, 0);
  endtask

  task automatic t_flags_prio();
    issue(S_REV, 3'd1);
    issue(S_ICON, 3'd1);
    issue(S_ADC, 3'd0);
    check("R13 status fields", statusByte, 8'h26);
    @(negedge clk);
    cmdVec[S_SRST] = 1'b1;
    cmdVec[S_DISP] = 1'b1;
    cmdData = 3'd1;
    @(negedge clk);
    cmdVec = '0;
    cmdData = '0;
    check("R12 reset beats write", statusByte, 8'h60);
    issue(S_PWR, 3'd5);
    issue(S_ALL, 3'd1);
    check("R2 sleep again", modeCode, 4);
    issue(S_DISP, 3'd1);
    check("R10 supply 5 after wake", supplyCtl, 5);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_normal();
        t_sleep_wake();
        t_standby_reset();
        t_flags_prio();
      end
      begin
        repeat (5000) @(posedge clk);
        nChecks++;
        nErrors++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end

endmodule